// File: doc/BRIEF.md
# DAC Sample Register Block with Selectable Update Trigger

This block stands between a byte-wide register bus and a 12-bit digital-to-analog converter. Software reaches three byte registers through it: a control byte, a high data byte and a low data byte. The block rebuilds a 12-bit code from the two data bytes. Five justification layouts are available, so software can store the sample left-aligned, right-aligned or at any position in between. The rebuilt code is copied into an output latch that feeds the converter. The control byte also drives the converter's run/shutdown line.

The trigger that loads the latch is a small state held in the control byte. There are four trigger states:

- `TRIG_ON_HIGH`: loads the latch on a bus write to the high data byte.
- `TRIG_ON_T3`: loads the latch on a single-cycle overflow pulse from timer 3.
- `TRIG_ON_T4`: loads the latch on an overflow pulse from timer 4.
- `TRIG_ON_T2`: loads the latch on an overflow pulse from timer 2.

The only transition between these states is a bus write to the control byte. The new trigger state takes effect at the clock edge of that write. With a timer trigger, samples can be placed at a fixed rate no matter when software writes them.

Top module: `dac_sample_regs`

## Requirements
- R1: After reset the control byte reads 0x00. The control byte is at bus address 0xD4. It reads back as {enable bit 7, 0, 0, mode bits 4:3, format bits 2:0}.
- R2: `conv_enable` equals control bit 7. When bit 7 is 0 the converter is shut down and its output is disabled. The new value appears one cycle after the control write.
- R3: Control bits 6 and 5 always read as 0, whatever value was written to them.
- R4: With mode 00, a write to the high byte loads the latch at that same clock edge. The loaded code is built from the newly written high byte and the low byte already stored.
- R5: Modes 01, 10 and 11 load the latch on a pulse of `tmr3_ovf`, `tmr4_ovf` and `tmr2_ovf` respectively. The latch uses the stored bytes and is updated one cycle after the pulse.
- R6: The latch holds its value in every cycle without a selected trigger. Pulses from unselected timers have no effect. A high-byte write has no effect on the latch in any timer mode.
- R7: The format field selects how the code is built:
  - 000 gives {high[3:0], low[7:0]}.
  - 001 gives {high[4:0], low[7:1]}.
  - 010 gives {high[5:0], low[7:2]}.
  - 011 gives {high[6:0], low[7:3]}.
- R8: Any format value with bit 2 set gives {high[7:0], low[7:4]}.
- R9: The high byte (address 0xD3) and the low byte (address 0xD2) reset to 0. Each reads back the last value written to it.
- R10: Clearing the enable bit leaves the latched code unchanged. Triggers still load the latch while the converter is disabled.
- R11: If a control write and a timer pulse land in the same cycle, the pulse is handled with the control value from before the write. This applies to both the trigger state and the format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| tmr4_ovf | input | 1 | Timer 4 overflow pulse |
| conv_enable | output | 1 | Converter run (1) or shutdown (0) |
| conv_code | output | 12 | Latched converter code |

## Verification
The bound checker checks four rules on every cycle:
- the reserved control bits read as zero;
- the run line follows the last control write;
- the high byte reads back what was last written to it;
- the latch stays still in any cycle where the selected trigger did not fire.

The bench's scenarios cover what is left:
- the bit layout of each of the eight format codes;
- the link between each timer pulse and its mode;
- the use of the stored low byte in a write-triggered update;
- loading while the converter is disabled;
- the old-control rule when a control write and a pulse coincide.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;

    // Trigger state held in the control byte (mode field, bits 4:3)
    typedef enum logic [1:0] {
        TRIG_ON_HIGH = 2'b00,
        TRIG_ON_T3   = 2'b01,
        TRIG_ON_T4   = 2'b10,
        TRIG_ON_T2   = 2'b11
    } trig_src_e;

    typedef struct packed {
        logic      enable;
        trig_src_e src;
        logic [2:0] fmt;
    } ctrl_t;

endpackage

// File: rtl/dac_regs_file.sv
module dac_regs_file
    import dac_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 'hD4,
    parameter logic [ADDR_W-1:0] ADDR_HI   = 'hD3,
    parameter logic [ADDR_W-1:0] ADDR_LO   = 'hD2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output ctrl_t             ctrl_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic [BYTE_W-1:0] lo_q,
    output logic              hi_wr
);

    logic ctrl_wr;
    logic lo_wr;
    logic unused_rsvd;

    assign ctrl_wr     = wr && (addr == ADDR_CTRL);
    assign hi_wr       = wr && (addr == ADDR_HI);
    assign lo_wr       = wr && (addr == ADDR_LO);
    assign unused_rsvd = ^wdata[6:5];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{enable: 1'b0, src: TRIG_ON_HIGH, fmt: 3'b000};
            hi_q   <= '0;
            lo_q   <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.enable <= wdata[7];
                ctrl_q.src    <= trig_src_e'(wdata[4:3]);
                ctrl_q.fmt    <= wdata[2:0];
            end
            if (hi_wr) hi_q <= wdata;
            if (lo_wr) lo_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL)
            rdata = BYTE_W'({ctrl_q.enable, 2'b00, ctrl_q.src, ctrl_q.fmt});
        else if (addr == ADDR_HI)
            rdata = hi_q;
        else if (addr == ADDR_LO)
            rdata = lo_q;
    end

endmodule

// File: rtl/dac_word_align.sv
module dac_word_align #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 12
) (
    input  logic [2:0]        fmt,
    input  logic [BYTE_W-1:0] hi,
    input  logic [BYTE_W-1:0] lo,
    output logic [WORD_W-1:0] word
);

    localparam int MAX_SHIFT = 2*BYTE_W - WORD_W;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

    logic [SHIFT_W-1:0]  shift;
    logic [2*BYTE_W-1:0] joined;

    // Format n (0..3) drops n low bits; any format with bit 2 set drops the maximum
    always_comb begin
        shift  = fmt[2] ? SHIFT_W'(MAX_SHIFT) : SHIFT_W'(fmt[1:0]);
        joined = {hi, lo} >> shift;
        word   = joined[WORD_W-1:0];
    end

endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dac_regs_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  trig_src_e         src,
    input  logic              hi_wr,
    input  logic              t2_ovf,
    input  logic              t3_ovf,
    input  logic              t4_ovf,
    input  logic [WORD_W-1:0] word_fresh,
    input  logic [WORD_W-1:0] word_stored,
    output logic [WORD_W-1:0] code_q
);

    logic              fire;
    logic [WORD_W-1:0] next_word;

    always_comb begin
        unique case (src)
            TRIG_ON_HIGH: begin
                fire      = hi_wr;
                next_word = word_fresh;
            end
            TRIG_ON_T3: begin
                fire      = t3_ovf;
                next_word = word_stored;
            end
            TRIG_ON_T4: begin
                fire      = t4_ovf;
                next_word = word_stored;
            end
            TRIG_ON_T2: begin
                fire      = t2_ovf;
                next_word = word_stored;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (fire)
            code_q <= next_word;
    end

endmodule

// File: rtl/dac_sample_regs.sv
module dac_sample_regs
    import dac_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8,
    parameter int WORD_W = 12,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 'hD4,
    parameter logic [ADDR_W-1:0] ADDR_HI   = 'hD3,
    parameter logic [ADDR_W-1:0] ADDR_LO   = 'hD2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tmr2_ovf,
    input  logic              tmr3_ovf,
    input  logic              tmr4_ovf,
    output logic              conv_enable,
    output logic [WORD_W-1:0] conv_code
);

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] lo_q;
    logic              hi_wr;
    logic [WORD_W-1:0] word_fresh;
    logic [WORD_W-1:0] word_stored;

    dac_regs_file #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W),
        .ADDR_CTRL(ADDR_CTRL), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .rdata(bus_rdata), .ctrl_q(ctrl_q),
        .hi_q(hi_q), .lo_q(lo_q), .hi_wr(hi_wr)
    );

    // Write-triggered path sees the incoming high byte in the same cycle
    dac_word_align #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) align_fresh_i (
        .fmt(ctrl_q.fmt), .hi(bus_wdata), .lo(lo_q), .word(word_fresh)
    );

    dac_word_align #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) align_stored_i (
        .fmt(ctrl_q.fmt), .hi(hi_q), .lo(lo_q), .word(word_stored)
    );

    dac_update_ctrl #(.WORD_W(WORD_W)) update_i (
        .clk(clk), .rst_n(rst_n), .src(ctrl_q.src), .hi_wr(hi_wr),
        .t2_ovf(tmr2_ovf), .t3_ovf(tmr3_ovf), .t4_ovf(tmr4_ovf),
        .word_fresh(word_fresh), .word_stored(word_stored),
        .code_q(conv_code)
    );

    assign conv_enable = ctrl_q.enable;

endmodule

// File: rtl/dac_sample_regs_chk.sv
module dac_sample_regs_chk #(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8,
    parameter int WORD_W = 12,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 'hD4,
    parameter logic [ADDR_W-1:0] ADDR_HI   = 'hD3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              tmr2_ovf,
    input logic              tmr3_ovf,
    input logic              tmr4_ovf,
    input logic              conv_enable,
    input logic [WORD_W-1:0] conv_code,
    input logic [1:0]        src_q,
    input logic [BYTE_W-1:0] hi_q
);

    logic ctrl_write;
    logic high_write;
    logic selected_event;

    assign ctrl_write     = bus_wr && (bus_addr == ADDR_CTRL);
    assign high_write     = bus_wr && (bus_addr == ADDR_HI);
    assign selected_event = (src_q == 2'b00 && high_write) ||
                            (src_q == 2'b01 && tmr3_ovf)   ||
                            (src_q == 2'b10 && tmr4_ovf)   ||
                            (src_q == 2'b11 && tmr2_ovf);

    assert_reserved_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTRL) |-> (bus_rdata[6:5] == 2'b00));

    assert_enable_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_write |=> (conv_enable == $past(bus_wdata[7])));

    assert_enable_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_write |=> $stable(conv_enable));

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !selected_event |=> $stable(conv_code));

    assert_high_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        high_write |=> (hi_q == $past(bus_wdata)));

endmodule

bind dac_sample_regs dac_sample_regs_chk #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W),
    .ADDR_CTRL(ADDR_CTRL), .ADDR_HI(ADDR_HI)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf), .tmr4_ovf(tmr4_ovf),
    .conv_enable(conv_enable), .conv_code(conv_code),
    .src_q(ctrl_q.src), .hi_q(hi_q)
);

// File: tb/dac_sample_regs_tb_top.sv
module dac_sample_regs_tb_top;

    localparam logic [7:0] A_CTRL = 8'hD4;
    localparam logic [7:0] A_HI   = 8'hD3;
    localparam logic [7:0] A_LO   = 8'hD2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        tmr2_ovf = 1'b0, tmr3_ovf = 1'b0, tmr4_ovf = 1'b0;
    logic        conv_enable;
    logic [11:0] conv_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scoreboard: {enable, code} expected after each driven edge
    logic [12:0] exp_q[$];
    string       tag_q[$];

    // Reference model state
    logic       m_en = 1'b0;
    logic [1:0] m_mode = 2'b00;
    logic [2:0] m_fmt = 3'b000;
    logic [7:0] m_hi = '0, m_lo = '0;
    logic [11:0] m_code = '0;

    always #2.5 clk = ~clk;

    dac_sample_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf), .tmr4_ovf(tmr4_ovf),
        .conv_enable(conv_enable), .conv_code(conv_code)
    );

    function automatic logic [11:0] ref_word(input logic [2:0] f, input logic [7:0] h,
                                             input logic [7:0] l);
        case (f)
            3'b000:  return {h[3:0], l};
            3'b001:  return {h[4:0], l[7:1]};
            3'b010:  return {h[5:0], l[7:2]};
            3'b011:  return {h[6:0], l[7:3]};
            default: return {h, l[7:4]};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    // Driver: one bus cycle with optional timer pulses; pushes the expected result
    task automatic step(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        input logic p2, input logic p3, input logic p4, input string tag);
        logic fire;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        tmr2_ovf = p2; tmr3_ovf = p3; tmr4_ovf = p4;
        fire = (m_mode == 2'b00 && wr && a == A_HI) || (m_mode == 2'b01 && p3) ||
               (m_mode == 2'b10 && p4) || (m_mode == 2'b11 && p2);
        if (fire)
            m_code = ref_word(m_fmt, (m_mode == 2'b00) ? d : m_hi, m_lo);
        if (wr && a == A_CTRL) begin
            m_en = d[7]; m_mode = d[4:3]; m_fmt = d[2:0];
        end
        if (wr && a == A_HI) m_hi = d;
        if (wr && a == A_LO) m_lo = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; tmr2_ovf = 1'b0; tmr3_ovf = 1'b0; tmr4_ovf = 1'b0;
        exp_q.push_back({m_en, m_code});
        tag_q.push_back(tag);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic pulse(input logic p2, input logic p3, input logic p4, input string tag);
        step(1'b0, A_LO, 8'h00, p2, p3, p4, tag);
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [7:0] expv, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, 32'(bus_rdata), 32'(expv));
    endtask

    // Monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [12:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " enable"}, 32'(conv_enable), 32'(e[12]));
            check({t, " code"}, 32'(conv_code), 32'(e[11:0]));
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 / R9 reset state
        check("R1 reset code", 32'(conv_code), 32'h0);
        check("R2 reset enable", 32'(conv_enable), 32'h0);
        rd_check(A_CTRL, 8'h00, "R1 ctrl reset");
        rd_check(A_HI, 8'h00, "R9 high reset");
        rd_check(A_LO, 8'h00, "R9 low reset");

        // R3 reserved bits, R2 enable
        wr_reg(A_CTRL, 8'hFF, "R2 enable on");
        rd_check(A_CTRL, 8'h9F, "R3 reserved read zero");
        wr_reg(A_CTRL, 8'h80, "R1 mode00 fmt000");
        rd_check(A_CTRL, 8'h80, "R1 ctrl readback");

        // R4 write-triggered update with stored low byte
        wr_reg(A_LO, 8'hAB, "R4 low write no update");
        wr_reg(A_HI, 8'h5C, "R4 high write update");
        wr_reg(A_HI, 8'h03, "R4 high reuse stored low");

        // R7 / R8 all formats
        for (int f = 0; f < 8; f++) begin
            wr_reg(A_CTRL, 8'h80 | 8'(f), f < 4 ? "R7 set fmt" : "R8 set fmt");
            wr_reg(A_LO, 8'(8'h3C + f * 8'h25), f < 4 ? "R7 low" : "R8 low");
            wr_reg(A_HI, 8'(8'hE7 - f * 8'h19), f < 4 ? "R7 layout" : "R8 layout");
        end
        rd_check(A_HI, 8'(8'hE7 - 7 * 8'h19), "R9 high readback");
        rd_check(A_LO, 8'(8'h3C + 7 * 8'h25), "R9 low readback");

        // R5 / R6 timer 3
        wr_reg(A_CTRL, 8'h88, "R5 mode01");
        wr_reg(A_LO, 8'h12, "R6 low hold");
        wr_reg(A_HI, 8'h34, "R6 high ignored in timer mode");
        pulse(1'b1, 1'b0, 1'b0, "R6 timer2 ignored");
        pulse(1'b0, 1'b0, 1'b1, "R6 timer4 ignored");
        pulse(1'b0, 1'b1, 1'b0, "R5 timer3 loads");
        pulse(1'b0, 1'b0, 1'b0, "R6 idle hold");

        // timer 4
        wr_reg(A_CTRL, 8'h91, "R5 mode10 fmt001");
        wr_reg(A_HI, 8'h56, "R6 high ignored");
        pulse(1'b1, 1'b1, 1'b0, "R6 timer2 timer3 ignored");
        pulse(1'b0, 1'b0, 1'b1, "R5 timer4 loads");

        // timer 2
        wr_reg(A_CTRL, 8'h98, "R5 mode11");
        wr_reg(A_LO, 8'hC9, "R6 low hold");
        pulse(1'b0, 1'b1, 1'b1, "R6 timer3 timer4 ignored");
        pulse(1'b1, 1'b0, 1'b0, "R5 timer2 loads");

        // R11 control write together with pulse uses old format
        wr_reg(A_HI, 8'hA5, "R6 high ignored");
        step(1'b1, A_CTRL, 8'h9C, 1'b1, 1'b0, 1'b0, "R11 old fmt on coincident pulse");
        pulse(1'b1, 1'b0, 1'b0, "R11 new fmt after write");
        step(1'b1, A_CTRL, 8'h80, 1'b1, 1'b0, 1'b0, "R11 old mode on coincident pulse");

        // R10 disable keeps latch, triggers still load
        wr_reg(A_CTRL, 8'h18, "R10 disable holds code");
        wr_reg(A_HI, 8'h7E, "R10 high ignored");
        pulse(1'b1, 1'b0, 1'b0, "R10 load while disabled");
        wr_reg(A_CTRL, 8'h00, "R10 mode00 disabled");
        wr_reg(A_HI, 8'h0F, "R10 write load while disabled");
        pulse(1'b0, 1'b0, 1'b0, "R10 final hold");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule